// File: doc/BRIEF.md
# Configuration Stream Error Monitor

This block follows a byte-serial configuration load through its framing stages and raises an active-low error flag when the load goes wrong. A load begins when the user pulls the configuration request line low while the block is idle. The first byte must be a fixed opening code. It is followed by a window-count byte. Each window then carries a 3-byte start address and a 3-byte end address. A closing code ends the load once the window count is used up.

Errors fall into two classes. Framing faults are a bad opening code, an illegal address range and a bad closing code. A framing fault pulses the abort output, drops the busy (hold-pins) signal and sends the block back to idle in the next cycle. A write-verify mismatch, reported from outside, only latches the error flag and the load carries on. Every error pulls the flag low exactly two cycles after the cycle in which the offending byte (or event) is presented. The flag then stays low until the next load starts from idle. A security lock left set by the previous load refuses a new load: the request is answered with an abort and an error, and the block never becomes busy.

Top module: `cfgStreamMon`

## Requirements
- R1: After reset, errN is 1, abortPulse is 0, busy is 0 and state is 0 (idle).
- R2: In idle with lockPrev low, a falling edge on cfgReqN in cycle k makes busy 1 and state 1 (expect opening code) in cycle k+1, and clears any latched error so errN is 1 in cycle k+1.
- R3: An error caused by the byte or event of cycle k drives errN low in cycle k+2 and not before; errN is still 1 in cycle k+1 when it was 1 before.
- R4: A first byte other than PRE_CODE (default 8'h3C) aborts the load: abortPulse is 1 and state is 0 in cycle k+1, and errN is low from cycle k+2.
- R5: Addresses are 3 bytes, least significant byte first. When the third end-address byte arrives and the end address is below the start address or above MAX_ADDR (default 24'h0FFFFF), the load aborts as in R4.
- R6: Once the window count is used up, a byte other than POST_CODE (default 8'hC3) aborts the load as in R4.
- R7: verifyMismatch high while busy drives errN low two cycles later without abort; the load continues, and errN stays low after the load ends until the next start.
- R8: With lockPrev high, a falling edge on cfgReqN in idle gives abortPulse 1 and busy 0 in cycle k+1 and errN low in cycle k+2.
- R9: State codes are 2 after the opening code, 3 while start-address bytes are taken, 4 while end-address bytes are taken and 5 while the closing code is awaited. A count byte of 0 goes straight to 5. A correct closing code returns the block to idle with abortPulse 0 and errN 1.
- R10: Bytes presented while idle, and cycles with byteValid low, leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | Stream byte strobe |
| byteData | input | 8 | Stream byte |
| cfgReqN | input | 1 | User configuration request, active low |
| verifyMismatch | input | 1 | External write-verify mismatch pulse |
| lockPrev | input | 1 | Security lock left by the previous load |
| errN | output | 1 | Active-low error flag |
| abortPulse | output | 1 | One-cycle pulse on a load abort |
| busy | output | 1 | Load in progress; configuration pins held |
| state | output | 3 | Current framing stage |

## Verification
On every cycle the assertions check these relations: an abort lands in idle, and an abort is followed by a low error flag one cycle later. A mismatch during a load pulls the flag low two cycles later, and a low flag stays low while the load is in progress. A lock-refused request never makes the block busy, and an unlocked request starts a load. Only the bench scenarios can show the parts that depend on stream contents. These are the address-range decisions, the byte order of addresses, the zero-count shortcut, a correct load ending without error, and the flag still being high one cycle after each offending byte.

// File: rtl/cfgmon_pkg.sv
package cfgmon_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PRE    = 3'd1,
    ST_COUNT  = 3'd2,
    ST_WSTART = 3'd3,
    ST_WEND   = 3'd4,
    ST_POST   = 3'd5
  } mon_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearErr;
    logic raiseErr;
    logic loadCount;
    logic decCount;
    logic shiftAddr;
    logic latchStart;
  } dp_strobe_t;
endpackage

// File: rtl/cfgmon_ctrl.sv
module cfgmon_ctrl
  import cfgmon_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 3,
  parameter logic [BYTE_W-1:0] PRE_CODE = 8'h3C,
  parameter logic [BYTE_W-1:0] POST_CODE = 8'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              cfgReqN,
  input  logic              verifyMismatch,
  input  logic              lockPrev,
  input  logic              addrBad,
  input  logic              countIsOne,
  output dp_strobe_t        strb,
  output mon_state_t        curState,
  output logic              abortPulse
);
  localparam int IDX_W = $clog2(ADDR_BYTES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  mon_state_t nextState;
  logic [IDX_W-1:0] fieldIdx, nextIdx;
  logic reqPrev, reqFall, frameErr, abortNow, lastByte;

  assign reqFall  = reqPrev & ~cfgReqN;
  assign lastByte = (fieldIdx == LAST_IDX);

  always_comb begin
    nextState = curState;
    nextIdx   = fieldIdx;
    strb      = '0;
    frameErr  = 1'b0;
    abortNow  = 1'b0;
    case (curState)
      ST_IDLE: begin
        if (reqFall) begin
          strb.clearErr = 1'b1;
          if (lockPrev) begin
            frameErr = 1'b1;
            abortNow = 1'b1;
          end else begin
            nextState = ST_PRE;
          end
        end
      end
      ST_PRE: begin
        if (byteValid) begin
          if (byteData == PRE_CODE) begin
            nextState = ST_COUNT;
          end else begin
            frameErr  = 1'b1;
            abortNow  = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      ST_COUNT: begin
        if (byteValid) begin
          strb.loadCount = 1'b1;
          nextIdx   = '0;
          nextState = (byteData == '0) ? ST_POST : ST_WSTART;
        end
      end
      ST_WSTART: begin
        if (byteValid) begin
          strb.shiftAddr = 1'b1;
          if (lastByte) begin
            strb.latchStart = 1'b1;
            nextIdx   = '0;
            nextState = ST_WEND;
          end else begin
            nextIdx = fieldIdx + 1'b1;
          end
        end
      end
      ST_WEND: begin
        if (byteValid) begin
          strb.shiftAddr = 1'b1;
          if (lastByte) begin
            nextIdx = '0;
            if (addrBad) begin
              frameErr  = 1'b1;
              abortNow  = 1'b1;
              nextState = ST_IDLE;
            end else begin
              strb.decCount = 1'b1;
              nextState = countIsOne ? ST_POST : ST_WSTART;
            end
          end else begin
            nextIdx = fieldIdx + 1'b1;
          end
        end
      end
      ST_POST: begin
        if (byteValid) begin
          nextState = ST_IDLE;
          if (byteData != POST_CODE) begin
            frameErr = 1'b1;
            abortNow = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
    strb.raiseErr = frameErr | (verifyMismatch & (curState != ST_IDLE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState   <= ST_IDLE;
      fieldIdx   <= '0;
      reqPrev    <= 1'b1;
      abortPulse <= 1'b0;
    end else begin
      curState   <= nextState;
      fieldIdx   <= nextIdx;
      reqPrev    <= cfgReqN;
      abortPulse <= abortNow;
    end
  end
endmodule

// File: rtl/cfgmon_dp.sv
module cfgmon_dp
  import cfgmon_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 3,
  parameter int unsigned MAX_ADDR = 32'h000F_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [BYTE_W-1:0] byteData,
  output logic              addrBad,
  output logic              countIsOne,
  output logic              errN
);
  localparam int ADDR_W = BYTE_W * ADDR_BYTES;
  localparam logic [ADDR_W-1:0] MAX_LIM = ADDR_W'(MAX_ADDR);

  logic [ADDR_W-1:0] fullAddr, startAddr;
  logic [BYTE_W-1:0] winCount;
  logic [1:0]        errStage;
  logic              errSticky;

  // Address assembly: bytes arrive least significant first
  generate
    if (ADDR_BYTES == 1) begin : g_single
      assign fullAddr = byteData;
    end else begin : g_multi
      logic [ADDR_W-BYTE_W-1:0] addrHold;
      assign fullAddr = {byteData, addrHold};
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               addrHold <= '0;
        else if (strb.shiftAddr) addrHold <= fullAddr[ADDR_W-1:BYTE_W];
      end
    end
  endgenerate

  assign addrBad    = (fullAddr < startAddr) || (fullAddr > MAX_LIM);
  assign countIsOne = (winCount == BYTE_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startAddr <= '0;
      winCount  <= '0;
    end else begin
      if (strb.latchStart) startAddr <= fullAddr;
      if (strb.loadCount)      winCount <= byteData;
      else if (strb.decCount)  winCount <= winCount - 1'b1;
    end
  end

  // Two-stage report pipeline, then a sticky flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errStage  <= '0;
      errSticky <= 1'b0;
    end else begin
      errStage <= {errStage[0], strb.raiseErr};
      if (strb.clearErr)     errSticky <= 1'b0;
      else if (errStage[1])  errSticky <= 1'b1;
    end
  end

  assign errN = ~(errStage[1] | errSticky);
endmodule

// File: rtl/cfgStreamMon.sv
module cfgStreamMon
  import cfgmon_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 3,
  parameter int unsigned MAX_ADDR = 32'h000F_FFFF,
  parameter logic [7:0] PRE_CODE = 8'h3C,
  parameter logic [7:0] POST_CODE = 8'hC3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic       cfgReqN,
  input  logic       verifyMismatch,
  input  logic       lockPrev,
  output logic       errN,
  output logic       abortPulse,
  output logic       busy,
  output logic [2:0] state
);
  dp_strobe_t strb;
  mon_state_t curState;
  logic addrBad, countIsOne;

  cfgmon_ctrl #(
    .ADDR_BYTES(ADDR_BYTES), .PRE_CODE(PRE_CODE), .POST_CODE(POST_CODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .cfgReqN(cfgReqN), .verifyMismatch(verifyMismatch), .lockPrev(lockPrev),
    .addrBad(addrBad), .countIsOne(countIsOne), .strb(strb),
    .curState(curState), .abortPulse(abortPulse)
  );

  cfgmon_dp #(
    .ADDR_BYTES(ADDR_BYTES), .MAX_ADDR(MAX_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteData(byteData),
    .addrBad(addrBad), .countIsOne(countIsOne), .errN(errN)
  );

  assign state = curState;
  assign busy  = (curState != ST_IDLE);
endmodule

// File: rtl/cfgmon_chk.sv
module cfgmon_chk (
  input logic       clk,
  input logic       rstN,
  input logic       byteValid,
  input logic       cfgReqN,
  input logic       verifyMismatch,
  input logic       lockPrev,
  input logic       errN,
  input logic       abortPulse,
  input logic       busy,
  input logic [2:0] state
);
  p_abort_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (state == 3'd0 && !busy));

  p_abort_err_delay_r3: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !errN);

  p_verify_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && verifyMismatch) |=> ##1 !errN);

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!errN && busy) |=> !errN);

  p_lock_refuse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd0 && lockPrev && $fell(cfgReqN)) |=> (abortPulse && !busy));

  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd0 && !lockPrev && $fell(cfgReqN)) |=> (busy && state == 3'd1));

  p_idle_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd0 && cfgReqN && (byteValid || !byteValid)) |=> state == 3'd0);
endmodule

bind cfgStreamMon cfgmon_chk u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .cfgReqN(cfgReqN),
  .verifyMismatch(verifyMismatch), .lockPrev(lockPrev), .errN(errN),
  .abortPulse(abortPulse), .busy(busy), .state(state)
);

// File: tb/cfgStreamMon_test.sv
`timescale 1ns/1ps
module cfgStreamMon_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic cfgReqN = 1'b1;
  logic verifyMismatch = 1'b0;
  logic lockPrev = 1'b0;
  logic errN, abortPulse, busy;
  logic [2:0] state;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    int    kind;   // 0 errN, 1 abortPulse, 2 busy, 3 state
    int    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  cfgStreamMon uut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .cfgReqN(cfgReqN), .verifyMismatch(verifyMismatch), .lockPrev(lockPrev),
    .errN(errN), .abortPulse(abortPulse), .busy(busy), .state(state)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int observe(int kind);
    case (kind)
      0: return int'(errN);
      1: return int'(abortPulse);
      2: return int'(busy);
      default: return int'(state);
    endcase
  endfunction

  // Monitor: pops items that fall due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        nChecks++;
        if (observe(sb[i].kind) != sb[i].val) begin
          nFails++;
          $display("FAIL %s: kind %0d at cycle %0d actual %0d expected %0d",
                   sb[i].tag, sb[i].kind, cyc, observe(sb[i].kind), sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_at(int at, int kind, int val, string tag);
    sb.push_back('{at, kind, val, tag});
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic sendByte(logic [7:0] b, logic vm);
    byteValid = 1'b1; byteData = b; verifyMismatch = vm;
    tick(1);
    byteValid = 1'b0; verifyMismatch = 1'b0;
  endtask

  task automatic sendAddr(int a);
    sendByte(a[7:0], 1'b0);
    sendByte(a[15:8], 1'b0);
    sendByte(a[23:16], 1'b0);
  endtask

  task automatic startLoad(string tag);
    cfgReqN = 1'b1; tick(1);
    cfgReqN = 1'b0;
    expect_at(cyc + 1, 2, 1, tag);
    expect_at(cyc + 1, 0, 1, tag);
    expect_at(cyc + 1, 3, 1, tag);
    tick(1);
  endtask

  // Final byte of a framing fault presented now: abort, then error
  task automatic expectAbort(string tag);
    expect_at(cyc + 1, 1, 1, tag);
    expect_at(cyc + 1, 3, 0, tag);
    expect_at(cyc + 1, 0, 1, tag);
    expect_at(cyc + 2, 0, 0, tag);
    expect_at(cyc + 5, 0, 0, tag);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    // R1 reset state
    expect_at(cyc, 0, 1, "R1"); expect_at(cyc, 1, 0, "R1");
    expect_at(cyc, 2, 0, "R1"); expect_at(cyc, 3, 0, "R1");
    tick(1);

    // R10 bytes in idle are ignored
    sendByte(8'h3C, 1'b0);
    expect_at(cyc, 3, 0, "R10");
    tick(1);

    // R9 two-window good load, R2 start
    startLoad("R2");
    sendByte(8'h3C, 1'b0);
    expect_at(cyc, 3, 2, "R9");
    tick(1);                        // R10 idle cycle, no byte
    expect_at(cyc, 3, 2, "R10");
    sendByte(8'h02, 1'b0);
    expect_at(cyc, 3, 3, "R9");
    sendAddr(32'h000100);
    expect_at(cyc, 3, 4, "R9");
    sendAddr(32'h000200);
    expect_at(cyc, 3, 3, "R9");
    sendAddr(32'h0F0300);
    sendAddr(32'h0F0300);            // equal start and end is legal
    expect_at(cyc, 3, 5, "R9");
    expect_at(cyc + 1, 1, 0, "R9");
    expect_at(cyc + 2, 0, 1, "R9");
    sendByte(8'hC3, 1'b0);
    expect_at(cyc, 3, 0, "R9");
    tick(3);
    expect_at(cyc, 0, 1, "R9");
    tick(1);

    // R9 zero window count
    startLoad("R2");
    sendByte(8'h3C, 1'b0);
    sendByte(8'h00, 1'b0);
    expect_at(cyc, 3, 5, "R9");
    sendByte(8'hC3, 1'b0);
    expect_at(cyc + 2, 0, 1, "R9");
    expect_at(cyc, 3, 0, "R9");
    tick(3);

    // R4 bad opening code, R3 delay
    startLoad("R2");
    expectAbort("R4");
    expect_at(cyc + 1, 0, 1, "R3");
    expect_at(cyc + 2, 0, 0, "R3");
    sendByte(8'h55, 1'b0);
    tick(4);

    // R2 a new start clears the latched error
    startLoad("R2");
    // R5 end below start
    sendByte(8'h3C, 1'b0);
    sendByte(8'h01, 1'b0);
    sendAddr(32'h000500);
    sendByte(8'h00, 1'b0);
    sendByte(8'h04, 1'b0);
    expect_at(cyc, 3, 4, "R5");
    expectAbort("R5");
    sendByte(8'h00, 1'b0);
    tick(4);

    // R5 end above the limit
    startLoad("R2");
    sendByte(8'h3C, 1'b0);
    sendByte(8'h01, 1'b0);
    sendAddr(32'h000000);
    sendByte(8'h00, 1'b0);
    sendByte(8'h00, 1'b0);
    expectAbort("R5");
    sendByte(8'h10, 1'b0);
    tick(4);

    // R6 bad closing code
    startLoad("R2");
    sendByte(8'h3C, 1'b0);
    sendByte(8'h01, 1'b0);
    sendAddr(32'h000010);
    sendAddr(32'h000020);
    expect_at(cyc, 3, 5, "R6");
    expectAbort("R6");
    sendByte(8'h77, 1'b0);
    tick(4);

    // R7 verify mismatch latches, no abort
    startLoad("R2");
    sendByte(8'h3C, 1'b0);
    expect_at(cyc + 1, 0, 1, "R7");
    expect_at(cyc + 1, 1, 0, "R7");
    expect_at(cyc + 1, 3, 5, "R7");
    expect_at(cyc + 2, 0, 0, "R7");
    sendByte(8'h00, 1'b1);
    expect_at(cyc + 1, 1, 0, "R7");
    expect_at(cyc + 1, 3, 0, "R7");
    sendByte(8'hC3, 1'b0);
    tick(3);
    expect_at(cyc, 0, 0, "R7");
    tick(1);

    // R8 security lock refuses the request
    lockPrev = 1'b1;
    cfgReqN = 1'b1; tick(1);
    cfgReqN = 1'b0;
    expect_at(cyc + 1, 1, 1, "R8");
    expect_at(cyc + 1, 2, 0, "R8");
    expect_at(cyc + 1, 0, 1, "R8");
    expect_at(cyc + 2, 0, 0, "R8");
    expect_at(cyc + 4, 3, 0, "R8");
    tick(6);
    lockPrev = 1'b0;
    startLoad("R2");
    tick(4);

    foreach (sb[i]) begin
      nFails++;
      $display("FAIL %s: item for cycle %0d never checked, actual none expected %0d",
               sb[i].tag, sb[i].at, sb[i].val);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule